// File: doc/BRIEF.md
# Dual-Channel PWM Generator

This block produces two pulse-width modulated logic outputs from one shared time base. A programmable 8-bit prescaler divides the clock by its reload value plus one and issues an advance strobe to a shared period counter. That counter steps through 255 states, 0 to 254, before it returns to 0. Each channel compares its own 8-bit duty register with the shared count and drives its output low while the duty value is the larger of the two. Otherwise the output is high.

Software reaches the three registers through a small write-enable, address and data port with a combinational read-back. Duty writes reach the comparison on the next clock edge, even in the middle of a period. A prescaler write waits until the current division interval ends. The count never reaches 255, so the extreme duty codes give fixed levels: 00h holds the output high and FFh holds it low.

Top module: `pwm_dual_gen`

## Requirements
- R1: The period counter advances once every P+1 clock cycles, where P is the reload value in use. When P is 0, it advances on every cycle.
- R2: The period counter counts 0, 1, ..., 254 and then returns to 0. It never holds 255.
- R3: Output n is low (0) whenever duty register n holds a value greater than the current count, and high (1) otherwise.
- R4: A duty value of 00h keeps its output high for the whole period. A duty value of FFh keeps its output low for the whole period.
- R5: A duty write changes the output from the following clock edge, whatever the position in the period.
- R6: A prescaler write does not shorten or lengthen the division interval already running. The new value is loaded when that interval ends.
- R7: Register addresses: 0 = prescaler reload, 1 = duty of channel 0, 2 = duty of channel 1. Reading an address returns the value last written there (the prescaler read gives the reload value, not the live count). Address 3 reads 0, and a write to it changes nothing.
- R8: Synchronous active-high reset clears all three registers and both counters to 0, so both outputs are high.
- R9: With a constant reload value P and a duty strictly between 00h and FFh, an output repeats every (P+1)*255 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address, used for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at reg_addr |
| pwm_n | output | 2 | PWM outputs, bit n belongs to channel n |

## Verification
On every cycle the assertions check the following:
- the count range, the wrap from 254 to 0, and single steps only on a prescaler strobe;
- the fixed levels for duty codes 00h and FFh;
- the state just after reset;
- that a prescaler write lands in its register.

Only the bench scenarios can show the rest: the exact output level at every count for every duty value, the immediate effect of duty writes in mid-period, the deferred effect of a prescaler write, the measured repetition period, and the read-back map.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

    // Register address of the prescaler reload value.
    localparam int PRESC_SEL = 0;

    // Register address of a channel's duty value.
    function automatic int cmp_sel(input int ch);
        return ch + 1;
    endfunction

    // Highest count the period counter holds for a given width (modulus 2^w - 1).
    function automatic int period_last(input int w);
        return (1 << w) - 2;
    endfunction

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pwm_level_e;

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
    import pwm_dual_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic [DW-1:0]           presc_q,
    output logic [NCH-1:0][DW-1:0]  cmp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            cmp_q   <= '0;
        end else if (we) begin
            if (addr == AW'(PRESC_SEL)) presc_q <= wdata;
            for (int ch = 0; ch < NCH; ch++) begin
                if (addr == AW'(cmp_sel(ch))) cmp_q[ch] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(PRESC_SEL)) rdata = presc_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr == AW'(cmp_sel(ch))) rdata = cmp_q[ch];
        end
    end

endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] reload,
    output logic          tick
);

    // Counts down from the reload value. The strobe fires at zero and
    // the reload is sampled only at that moment.
    logic [DW-1:0] div_q;

    assign tick = (div_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= reload;
        else           div_q <= div_q - DW'(1);
    end

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt
    import pwm_dual_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [DW-1:0] cnt_q
);

    localparam logic [DW-1:0] LAST = DW'(period_last(DW));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + DW'(1);
        end
    end

endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
    import pwm_dual_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cmp,
    input  logic [DW-1:0] cnt,
    output logic          pwm_n
);

    pwm_level_e lvl;

    always_comb begin
        lvl = (cmp > cnt) ? LVL_LOW : LVL_HIGH;
    end

    assign pwm_n = lvl;

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_n
);

    logic [DATA_W-1:0]              presc_q;
    logic [NUM_CH-1:0][DATA_W-1:0]  cmp_q;
    logic                           tick;
    logic [DATA_W-1:0]              cnt_q;

    pwm_reg_bank #(.DW(DATA_W), .NCH(NUM_CH), .AW(ADDR_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .presc_q (presc_q),
        .cmp_q   (cmp_q)
    );

    pwm_tick_div #(.DW(DATA_W)) div_i (
        .clk    (clk),
        .rst    (rst),
        .reload (presc_q),
        .tick   (tick)
    );

    pwm_period_cnt #(.DW(DATA_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cnt_q (cnt_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwm_cmp_chan #(.DW(DATA_W)) chan_i (
            .cmp   (cmp_q[ch]),
            .cnt   (cnt_q),
            .pwm_n (pwm_n[ch])
        );
    end

endmodule

// File: rtl/pwm_dual_gen_chk.sv
module pwm_dual_gen_chk
    import pwm_dual_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic [DW-1:0]          cnt,
    input logic [DW-1:0]          presc,
    input logic [NCH-1:0][DW-1:0] cmp,
    input logic [NCH-1:0]         pwm_n,
    input logic                   we,
    input logic [AW-1:0]          addr,
    input logic [DW-1:0]          wdata
);

    localparam logic [DW-1:0] LAST = DW'(period_last(DW));
    localparam logic [DW-1:0] ALL1 = '1;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == LAST) |=> (cnt == '0));

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != LAST) |=> (cnt == $past(cnt) + DW'(1)));

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && presc == '0 && pwm_n == '1));

    assert_presc_write_R7: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(PRESC_SEL)) |=> (presc == $past(wdata)));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lvl
        assert_full_low_R4: assert property (@(posedge clk) disable iff (rst)
            (cmp[ch] == ALL1) |-> (pwm_n[ch] == 1'b0));

        assert_zero_high_R4: assert property (@(posedge clk) disable iff (rst)
            (cmp[ch] == '0) |-> (pwm_n[ch] == 1'b1));
    end

endmodule

bind pwm_dual_gen pwm_dual_gen_chk #(.DW(DATA_W), .NCH(NUM_CH), .AW(ADDR_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .cnt   (cnt_q),
    .presc (presc_q),
    .cmp   (cmp_q),
    .pwm_n (pwm_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata)
);

// File: tb/pwm_dual_gen_tb_top.sv
module pwm_dual_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] pwm_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state, computed from the requirements.
    int m_div   = 0;
    int m_cnt   = 0;
    int m_presc = 0;
    int m_cmp0  = 0;
    int m_cmp1  = 0;

    always #4 clk = ~clk;

    pwm_dual_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_n     (pwm_n)
    );

    // R1 R2 R6: divider interval P+1, reload taken only at interval end; count wraps after 254.
    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_cnt = 0; m_presc = 0; m_cmp0 = 0; m_cmp1 = 0;
        end else begin
            if (m_div == 0) begin
                m_cnt = (m_cnt == 254) ? 0 : m_cnt + 1;
                m_div = m_presc;
            end else begin
                m_div = m_div - 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_presc = reg_wdata;
                    2'd1: m_cmp0  = reg_wdata;
                    2'd2: m_cmp1  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        int e0 = (m_cmp0 > m_cnt) ? 0 : 1;
        int e1 = (m_cmp1 > m_cnt) ? 0 : 1;
        check(pwm_n[0] == e0[0], req, pwm_n[0], e0);
        check(pwm_n[1] == e1[0], req, pwm_n[1], e1);
    endtask

    task automatic step(input string req);
        @(negedge clk);
        check_outs(req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(req);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp[7:0], req, reg_rdata, exp);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        rd(2'd0, 0, "R8"); rd(2'd1, 0, "R8"); rd(2'd2, 0, "R8");
        check(pwm_n == 2'b11, "R8", pwm_n, 3);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) step("R8");

        // R7: read back the map
        wr(2'd0, 8'h00, "R7");
        wr(2'd1, 8'h5A, "R7");
        wr(2'd2, 8'hC3, "R7");
        wr(2'd3, 8'hFF, "R7");
        rd(2'd1, 'h5A, "R7"); rd(2'd2, 'hC3, "R7"); rd(2'd0, 0, "R7"); rd(2'd3, 0, "R7");

        // R3 R4 R5: every duty value over a full period, prescaler 0
        for (int v = 0; v < 256; v++) begin
            string tag = (v == 0 || v == 255) ? "R4" : "R5";
            wr(2'd1, v[7:0], tag);
            wr(2'd2, 8'(255 - v), tag);
            for (int c = 0; c < 255; c++) step((v == 0 || v == 255) ? "R4" : "R3");
        end

        // R1: prescaler 3, checked over several periods
        wr(2'd0, 8'd3, "R1");
        rd(2'd0, 3, "R7");
        wr(2'd1, 8'd40, "R1");
        wr(2'd2, 8'd200, "R1");
        for (int c = 0; c < 2200; c++) step("R1");

        // R6: prescaler change in the middle of an interval
        wr(2'd0, 8'd7, "R6");
        for (int c = 0; c < 21; c++) step("R6");
        wr(2'd0, 8'd1, "R6");
        for (int c = 0; c < 700; c++) step("R6");

        // R9: measured repetition period with prescaler 2
        wr(2'd0, 8'd2, "R9");
        wr(2'd1, 8'd128, "R9");
        for (int c = 0; c < 1600; c++) step("R9");
        begin
            int t_first = -1;
            int t_second = -1;
            logic prev = pwm_n[0];
            for (int c = 0; c < 3000 && t_second < 0; c++) begin
                step("R9");
                if (prev == 1'b1 && pwm_n[0] == 1'b0) begin
                    if (t_first < 0) t_first = c;
                    else t_second = c;
                end
                prev = pwm_n[0];
            end
            check(t_first >= 0 && (t_second - t_first) == 765, "R9", t_second - t_first, 765);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule